// File: doc/BRIEF.md
# Bus-Matching Endian Read Port

This block sits between a 36-bit first-word-fall-through queue and a narrower read port. The queue only ever stores full 36-bit long-words. The block hands each stored long-word to the reader in one of three forms: as one 36-bit long-word, as two 18-bit words, or as four 9-bit bytes. In the split modes the pieces come out either from the most significant end first or from the least significant end first.

The bus width and the piece order are fixed for the whole run. Both are captured once, at the first clock edge after the active-low reset is released, and they hold until the next reset. A piece counter moves forward on every accepted read. The block asks the queue for the next long-word only when the reader takes the final piece of the current one. The read data is combinational from the queue head, so a read strobe sees its piece in the same cycle.

Top module: `bm_read_port`

## Requirements
- R1: While `rst_ni` is low, and during the first clock cycle after it rises, reads are not accepted: `fifo_pop_o` stays 0 and the piece position stays at the first piece.
- R2: Width decode: `match_sel_i`=0 selects 36-bit mode. `match_sel_i`=1 with `size_sel_i`=0 selects 18-bit mode. `match_sel_i`=1 with `size_sel_i`=1 selects 9-bit mode.
- R3: In 36-bit mode, every accepted read returns the whole head word on `rd_data_o[35:0]` and pulses `fifo_pop_o` in that same cycle.
- R4: In 18-bit mode, each long-word takes two accepted reads. `fifo_pop_o` is 1 only during the second of them.
- R5: In 9-bit mode, each long-word takes four accepted reads. `fifo_pop_o` is 1 only during the fourth of them.
- R6: With `big_end_i`=1 captured, the pieces come out from the highest slice downward. Slice i means bits [i*W+W-1 : i*W].
- R7: With `big_end_i`=0 captured, the pieces come out from slice 0 upward.
- R8: In 36-bit mode, the value of `big_end_i` has no effect on `rd_data_o`.
- R9: In 18-bit mode, bits 35:18 of `rd_data_o` are 0. In 9-bit mode, bits 35:9 are 0.
- R10: While `fifo_empty_i` is 1, `rd_data_o` is 0 and `fifo_pop_o` is 0. A read strobe in that state does not move the piece position.
- R11: After the capture edge, changes on `size_sel_i`, `match_sel_i` or `big_end_i` have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| size_sel_i | input | 1 | Chooses 9-bit (1) or 18-bit (0) when matching is enabled |
| match_sel_i | input | 1 | Enables bus matching; 0 selects 36-bit mode |
| big_end_i | input | 1 | Piece order, 1 = most significant first |
| rd_i | input | 1 | Read strobe |
| fifo_data_i | input | 36 | Head word of the queue |
| fifo_empty_i | input | 1 | Queue has no word |
| fifo_pop_o | output | 1 | Advance the queue head |
| rd_data_o | output | 36 | Current piece, right-aligned |

## Verification
On every cycle, the assertions check the following:
- no pop while the queue is empty or before the configuration is captured;
- a pop on every accepted read in 36-bit mode;
- the piece position returning to the first piece after a pop;
- the captured configuration staying frozen;
- the unused upper bits staying at zero.

The actual piece order, the number of reads each long-word takes, and the indifference to endian in 36-bit mode can only be shown by the bench's sweeps. The same holds for ignoring select changes made after reset, and for a strobe on an empty queue leaving the position alone. These sweeps read words through every width and order pairing and compare each piece with an arithmetically computed slice.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    BUS_LONG = 2'd0,
    BUS_HALF = 2'd1,
    BUS_QTR  = 2'd2
  } bus_size_e;

  function automatic bus_size_e decode_size(input logic match_sel, input logic size_sel);
    if (!match_sel)    return BUS_LONG;
    else if (size_sel) return BUS_QTR;
    else               return BUS_HALF;
  endfunction
endpackage

// File: rtl/bm_cfg_latch.sv
module bm_cfg_latch
  import bm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      size_sel_i,
  input  logic      match_sel_i,
  input  logic      big_end_i,
  output bus_size_e size_o,
  output logic      big_o,
  output logic      cfg_ok_o
);
  bus_size_e size_q;
  logic      big_q;
  logic      ok_q;

  // capture once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= BUS_LONG;
      big_q  <= 1'b0;
      ok_q   <= 1'b0;
    end else if (!ok_q) begin
      size_q <= decode_size(match_sel_i, size_sel_i);
      big_q  <= big_end_i;
      ok_q   <= 1'b1;
    end
  end

  assign size_o   = size_q;
  assign big_o    = big_q;
  assign cfg_ok_o = ok_q;

  a_r11_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |=> ($stable(size_q) && $stable(big_q) && ok_q));
endmodule

// File: rtl/bm_piece_ctr.sv
module bm_piece_ctr
  import bm_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bus_size_e        size_i,
  input  logic             take_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_QTR  = CNT_W'(3);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    unique case (size_i)
      BUS_QTR:  last_idx = LAST_QTR;
      BUS_HALF: last_idx = LAST_HALF;
      default:  last_idx = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (take_i) cnt_q <= (cnt_q == last_idx) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == last_idx);

  a_r5_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_idx);
endmodule

// File: rtl/bm_slicer.sv
module bm_slicer
  import bm_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned CNT_W  = 2
) (
  input  logic [DATA_W-1:0] word_i,
  input  bus_size_e         size_i,
  input  logic              big_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] piece_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned QTR_W  = DATA_W / 4;
  localparam int unsigned N_HALF = 2;
  localparam int unsigned N_QTR  = 4;

  logic [HALF_W-1:0] halves [N_HALF];
  logic [QTR_W-1:0]  qtrs   [N_QTR];

  for (genvar gi = 0; gi < N_HALF; gi++) begin : g_half
    assign halves[gi] = word_i[gi*HALF_W +: HALF_W];
  end
  for (genvar gi = 0; gi < N_QTR; gi++) begin : g_qtr
    assign qtrs[gi] = word_i[gi*QTR_W +: QTR_W];
  end

  logic       h_idx;
  logic [1:0] q_idx;

  // big endian walks slices downward, little upward
  assign h_idx = big_i ? ~cnt_i[0] : cnt_i[0];
  assign q_idx = big_i ? (2'd3 - cnt_i[1:0]) : cnt_i[1:0];

  always_comb begin
    unique case (size_i)
      BUS_HALF: piece_o = DATA_W'(halves[h_idx]);
      BUS_QTR:  piece_o = DATA_W'(qtrs[q_idx]);
      default:  piece_o = word_i;
    endcase
  end
endmodule

// File: rtl/bm_read_port.sv
module bm_read_port
  import bm_pkg::*;
#(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              size_sel_i,
  input  logic              match_sel_i,
  input  logic              big_end_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic              fifo_empty_i,
  output logic              fifo_pop_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned CNT_W  = 2;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned QTR_W  = DATA_W / 4;

  bus_size_e         size;
  logic              big;
  logic              cfg_ok;
  logic              take;
  logic              last;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] piece;

  bm_cfg_latch u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .size_sel_i  (size_sel_i),
    .match_sel_i (match_sel_i),
    .big_end_i   (big_end_i),
    .size_o      (size),
    .big_o       (big),
    .cfg_ok_o    (cfg_ok)
  );

  assign take = rd_i & ~fifo_empty_i & cfg_ok;

  bm_piece_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .size_i (size),
    .take_i (take),
    .cnt_o  (cnt),
    .last_o (last)
  );

  bm_slicer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_slice (
    .word_i  (fifo_data_i),
    .size_i  (size),
    .big_i   (big),
    .cnt_i   (cnt),
    .piece_o (piece)
  );

  assign fifo_pop_o = take & last;
  assign rd_data_o  = fifo_empty_i ? '0 : piece;

  a_r10_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_empty_i |-> (!fifo_pop_o && rd_data_o == '0));
  a_r1_no_pop_unconfigured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ok |-> !fifo_pop_o);
  a_r3_long_pops_each: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size == BUS_LONG && rd_i && !fifo_empty_i && cfg_ok) |-> fifo_pop_o);
  a_r4_restart_after_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> (cnt == '0));
  a_r9_half_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size == BUS_HALF) |-> (rd_data_o[DATA_W-1:HALF_W] == '0));
  a_r9_qtr_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size == BUS_QTR) |-> (rd_data_o[DATA_W-1:QTR_W] == '0));
endmodule

// File: tb/bm_read_port_tb.sv
module bm_read_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        size_sel = 1'b0, match_sel = 1'b0, big_end = 1'b0, rd = 1'b0;
  logic [35:0] fifo_data;
  logic        fifo_empty, pop;
  logic [35:0] rd_data;
  logic [35:0] mem [16];
  int          head, fill;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  bm_read_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .size_sel_i(size_sel), .match_sel_i(match_sel),
    .big_end_i(big_end), .rd_i(rd), .fifo_data_i(fifo_data), .fifo_empty_i(fifo_empty),
    .fifo_pop_o(pop), .rd_data_o(rd_data)
  );

  assign fifo_empty = (head >= fill);
  assign fifo_data  = fifo_empty ? 36'h0 : mem[head[3:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) head <= 0;
    else if (pop && head < fill) head <= head + 1;
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
    end
  end

  task automatic chk(input logic [35:0] act, input logic [35:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] gen_word(input int i);
    return {4'(i + 3), 32'hA5C3_0F96 ^ (32'(i) * 32'h0123_4567)};
  endfunction

  // mode 0 = 36-bit, 1 = 18-bit, 2 = 9-bit
  function automatic logic [35:0] exp_piece(input logic [35:0] w, input int mode,
                                            input bit be, input int k);
    int wd, n, idx;
    wd = (mode == 0) ? 36 : (mode == 1) ? 18 : 9;
    n  = 36 / wd;
    idx = be ? (n - 1 - k) : k;
    return (w >> (idx * wd)) & ((36'h1 << wd) - 36'h1);
  endfunction

  task automatic do_reset(input int mode, input bit be);
    @(negedge clk);
    rst_n = 1'b0; rd = 1'b0; fill = 0;
    match_sel = (mode != 0); size_sel = (mode == 2); big_end = be;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input int i);
    mem[fill[3:0]] = gen_word(i);
    fill = fill + 1;
  endtask

  // one read at negedge; checks data and pop before the next edge
  task automatic do_read(input logic [35:0] exp_d, input bit exp_p, input string tag);
    rd = 1'b1;
    #1;
    chk(rd_data, exp_d, tag);
    chk({35'h0, pop}, {35'h0, exp_p}, {tag, " pop"});
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    fill = 0;
    // R1: no acceptance during reset or in the capture cycle
    do_reset(0, 1'b0);
    push(0);
    rst_n = 1'b0; rd = 1'b1;
    #1 chk({35'h0, pop}, 36'h0, "R1 pop in reset");
    rst_n = 1'b1;
    #1 chk({35'h0, pop}, 36'h0, "R1 pop before capture");
    @(negedge clk);
    chk(36'(head), 36'h0, "R1 head unchanged");
    #1 chk({35'h0, pop}, 36'h1, "R1 pop after capture");
    @(negedge clk); rd = 1'b0;

    // R2..R7: sweep every width and order
    for (int mode = 0; mode < 3; mode++) begin
      for (int be = 0; be < 2; be++) begin
        int n;
        n = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
        do_reset(mode, be[0]);
        @(negedge clk);
        for (int w = 0; w < 3; w++) push(w + mode * 5 + be);
        for (int w = 0; w < 3; w++) begin
          for (int k = 0; k < n; k++) begin
            logic [35:0] wv;
            wv = gen_word(w + mode * 5 + be);
            if (mode == 0)      do_read(exp_piece(wv, 0, be[0], 0), 1'b1, "R3 R8 long word");
            else if (mode == 1) do_read(exp_piece(wv, 1, be[0], k), k == n - 1,
                                        be ? "R4 R6 R9 half big" : "R4 R7 R9 half little");
            else                do_read(exp_piece(wv, 2, be[0], k), k == n - 1,
                                        be ? "R5 R6 R9 qtr big" : "R5 R7 R9 qtr little");
          end
        end
        chk(36'(head), 36'd3, "R2 words consumed");
        // R10: empty strobe, then resume at first piece
        rd = 1'b1;
        #1 chk(rd_data, 36'h0, "R10 empty data");
        chk({35'h0, pop}, 36'h0, "R10 empty pop");
        @(negedge clk); rd = 1'b0;
        push(9);
        do_read(exp_piece(gen_word(9), mode, be[0], 0), n == 1, "R10 position kept");
      end
    end

    // R8: long mode with opposite order bit gives same word
    do_reset(0, 1'b1);
    @(negedge clk);
    push(7);
    do_read(gen_word(7), 1'b1, "R8 order ignored");

    // R11: select changes after capture ignored
    do_reset(2, 1'b0);
    @(negedge clk);
    push(4);
    match_sel = 1'b0; size_sel = 1'b0; big_end = 1'b1;
    for (int k = 0; k < 4; k++)
      do_read(exp_piece(gen_word(4), 2, 1'b0, k), k == 3, "R11 config frozen");

    report();
  end
endmodule